// File: doc/BRIEF.md
# PCI Target Write Handshake Controller

This block is a reduced 32-bit PCI bus target that accepts memory writes with a single data phase. It watches the active-low frame and initiator-ready lines, the multiplexed address/data lines and the command/byte-enable lines. It answers by driving active-low device-select and target-ready. Each address phase is captured and decoded against six fixed, 4 KB aligned base regions. On a match, the block raises a one-hot region-hit vector that the back end can use as a chip select.

Device-select follows the decode with slow timing. The back end paces the data phase through an active-low ready input. Target-ready and a registered transfer strobe appear together one cycle after the initiator and the back end are both ready. The data word and the byte enables are presented while the strobe is active. The block releases the bus one cycle later. It is then ready for a fast back-to-back address phase in the very next clock, with no idle cycle.

Top module: `pci_wr_target`

## Requirements
- R1: When frame_n is sampled low while the target is idle, the outputs after that edge show be_addr equal to the sampled ad and be_rnw equal to the inverse of cbe_n bit 0, so a memory write command gives be_rnw = 0.
- R2: One clock after the address phase, be_hit shows bit i set only when address bits [31:12] equal region i's base bits [31:12] and the command is memory write (cbe_n = 4'b0111). With the default bases, region i starts at (i+1)*0x1000. Otherwise be_hit is zero, and it never has more than one bit set.
- R3: With a hit, devsel_n goes low one clock after be_hit becomes nonzero. It stays low until the transfer completes.
- R4: When no region matches or the command is not a memory write, devsel_n, trdy_n and be_xfer_n stay high. The target returns to idle once frame_n and irdy_n are both sampled high.
- R5: trdy_n and be_xfer_n go low together in the cycle after an edge that samples irdy_n low and be_rdy_n low while devsel_n is low. be_xfer_n is never low unless both inputs were low at the previous edge.
- R6: At that same edge, be_data captures ad and be_byten captures the inverse of cbe_n (active-high, bit k covers byte k). Both hold while be_xfer_n is low.
- R7: Every cycle in which irdy_n or be_rdy_n is high inserts a wait state, with no upper limit. trdy_n and be_xfer_n stay high throughout.
- R8: In the cycle after the one with be_xfer_n low, devsel_n, trdy_n and be_xfer_n are high and be_hit is zero.
- R9: A new address phase sampled at the edge right after release is accepted and decoded like any other (fast back-to-back).
- R10: While rst_n is sampled low, devsel_n, trdy_n and be_xfer_n are high after the edge, and be_hit and be_byten are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Bus frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phase |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| be_rdy_n | input | 1 | Back-end ready, active low |
| be_addr | output | 32 | Captured transaction address |
| be_hit | output | 6 | One-hot region hit |
| be_rnw | output | 1 | 1 = read, 0 = write, from the captured command |
| be_xfer_n | output | 1 | Data transfer strobe, active low |
| be_data | output | 32 | Captured write data |
| be_byten | output | 4 | Captured byte enables, active high |

## Verification
A wrong decode state shows up at the ports within one clock of the address phase. A wrong one-hot vector or a missing hit appears on be_hit, and a missing device-select follows one clock later. A controller stuck in its wait state shows as trdy_n staying high after both ready inputs are low. A controller that leaves the transfer state too late shows as a missed release one cycle after the strobe, or as the next back-to-back address being lost. Each of these appears within two clocks of the faulty transition.

// File: rtl/pci_wr_target_pkg.sv
package pci_wr_target_pkg;

    localparam int AD_W        = 32;
    localparam int BE_W        = 4;
    localparam int NUM_REGIONS = 6;

    localparam logic [BE_W-1:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_SELECT,
        ST_WAIT,
        ST_XFER,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e             state;
        logic [AD_W-1:0]        addr;
        logic [BE_W-1:0]        cmd;
        logic                   rnw;
        logic [NUM_REGIONS-1:0] hit;
        logic                   devsel_n;
        logic                   trdy_n;
        logic                   xfer_n;
        logic [AD_W-1:0]        data;
        logic [BE_W-1:0]        byten;
    } tgt_regs_t;

    localparam tgt_regs_t REGS_RESET = '{
        state:    ST_IDLE,
        addr:     '0,
        cmd:      '0,
        rnw:      1'b1,
        hit:      '0,
        devsel_n: 1'b1,
        trdy_n:   1'b1,
        xfer_n:   1'b1,
        data:     '0,
        byten:    '0
    };

endpackage

// File: rtl/pci_wr_region_match.sv
module pci_wr_region_match #(
    parameter int TAG_W   = 20,
    parameter int REGIONS = 6,
    parameter logic [REGIONS-1:0][TAG_W-1:0] TAGS = '0
) (
    input  logic [TAG_W-1:0]   addr_tag,
    output logic [REGIONS-1:0] hit
);
    for (genvar g = 0; g < REGIONS; g++) begin : g_cmp
        assign hit[g] = (addr_tag == TAGS[g]);
    end
endmodule

// File: rtl/pci_wr_ctrl.sv
module pci_wr_ctrl
    import pci_wr_target_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    input  logic [AD_W-1:0]        ad,
    input  logic [BE_W-1:0]        cbe_n,
    input  logic                   be_rdy_n,
    input  logic [NUM_REGIONS-1:0] match_hit,
    output tgt_regs_t              regs
);
    tgt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!frame_n) begin
                    r_d.addr  = ad;
                    r_d.cmd   = cbe_n;
                    r_d.rnw   = ~cbe_n[0];
                    r_d.state = ST_DECODE;
                end
            end
            ST_DECODE: begin
                r_d.hit   = (r_q.cmd == CMD_MEM_WRITE) ? match_hit : '0;
                r_d.state = ((r_q.cmd == CMD_MEM_WRITE) && (|match_hit))
                            ? ST_SELECT : ST_IGNORE;
            end
            ST_SELECT: begin
                r_d.devsel_n = 1'b0;
                r_d.state    = ST_WAIT;
            end
            ST_WAIT: begin
                if (!irdy_n && !be_rdy_n) begin
                    r_d.trdy_n = 1'b0;
                    r_d.xfer_n = 1'b0;
                    r_d.data   = ad;
                    r_d.byten  = ~cbe_n;
                    r_d.state  = ST_XFER;
                end
            end
            ST_XFER: begin
                r_d.devsel_n = 1'b1;
                r_d.trdy_n   = 1'b1;
                r_d.xfer_n   = 1'b1;
                r_d.hit      = '0;
                r_d.state    = ST_IDLE;
            end
            ST_IGNORE: begin
                if (frame_n && irdy_n) r_d.state = ST_IDLE;
            end
            default: r_d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign regs = r_q;
endmodule

// File: rtl/pci_wr_target.sv
module pci_wr_target
    import pci_wr_target_pkg::*;
#(
    parameter int REGION_SHIFT = 12,
    parameter logic [NUM_REGIONS-1:0][AD_W-1:0] REGION_BASES = {
        32'h0000_6000, 32'h0000_5000, 32'h0000_4000,
        32'h0000_3000, 32'h0000_2000, 32'h0000_1000}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    input  logic [AD_W-1:0]        ad,
    input  logic [BE_W-1:0]        cbe_n,
    output logic                   devsel_n,
    output logic                   trdy_n,
    input  logic                   be_rdy_n,
    output logic [AD_W-1:0]        be_addr,
    output logic [NUM_REGIONS-1:0] be_hit,
    output logic                   be_rnw,
    output logic                   be_xfer_n,
    output logic [AD_W-1:0]        be_data,
    output logic [BE_W-1:0]        be_byten
);
    localparam int TAG_W = AD_W - REGION_SHIFT;

    function automatic logic [NUM_REGIONS-1:0][TAG_W-1:0] make_tags();
        logic [NUM_REGIONS-1:0][TAG_W-1:0] t;
        for (int i = 0; i < NUM_REGIONS; i++)
            t[i] = REGION_BASES[i][AD_W-1:REGION_SHIFT];
        return t;
    endfunction

    localparam logic [NUM_REGIONS-1:0][TAG_W-1:0] TAGS = make_tags();

    tgt_regs_t              regs;
    logic [NUM_REGIONS-1:0] match_hit;

    pci_wr_region_match #(
        .TAG_W  (TAG_W),
        .REGIONS(NUM_REGIONS),
        .TAGS   (TAGS)
    ) u_match (
        .addr_tag(regs.addr[AD_W-1:REGION_SHIFT]),
        .hit     (match_hit)
    );

    pci_wr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .ad       (ad),
        .cbe_n    (cbe_n),
        .be_rdy_n (be_rdy_n),
        .match_hit(match_hit),
        .regs     (regs)
    );

    assign devsel_n  = regs.devsel_n;
    assign trdy_n    = regs.trdy_n;
    assign be_addr   = regs.addr;
    assign be_hit    = regs.hit;
    assign be_rnw    = regs.rnw;
    assign be_xfer_n = regs.xfer_n;
    assign be_data   = regs.data;
    assign be_byten  = regs.byten;
endmodule

// File: rtl/pci_wr_target_chk.sv
module pci_wr_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irdy_n,
    input logic       be_rdy_n,
    input logic       devsel_n,
    input logic       trdy_n,
    input logic [5:0] be_hit,
    input logic       be_xfer_n
);
    assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(be_hit));

    assert_devsel_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> ($past(be_hit) != 6'd0));

    assert_xfer_needs_both_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(be_xfer_n) |-> (!$past(irdy_n) && !$past(be_rdy_n) && !$past(devsel_n)));

    assert_trdy_with_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n == !be_xfer_n) && (be_xfer_n || (!devsel_n && be_hit != 6'd0)));

    assert_release_after_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !be_xfer_n |=> (be_xfer_n && trdy_n && devsel_n && be_hit == 6'd0));

    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (devsel_n && trdy_n && be_xfer_n && be_hit == 6'd0));
endmodule

bind pci_wr_target pci_wr_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irdy_n   (irdy_n),
    .be_rdy_n (be_rdy_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .be_hit   (be_hit),
    .be_xfer_n(be_xfer_n)
);

// File: tb/pci_wr_target_test.sv
module pci_wr_target_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, be_rdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        devsel_n, trdy_n, be_rnw, be_xfer_n;
    logic [31:0] be_addr, be_data;
    logic [5:0]  be_hit;
    logic [3:0]  be_byten;

    int n_checks = 0, n_fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pci_wr_target uut (.*);

    function automatic logic [5:0] exp_hit(input logic [31:0] a, input logic [3:0] c);
        logic [5:0] h = '0;
        for (int i = 0; i < 6; i++)
            if (c == 4'b0111 && a[31:12] == 20'(i + 1)) h[i] = 1'b1;
        return h;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Starts at a negedge, returns at a negedge right after release.
    task automatic run_tx(input logic [31:0] a, input logic [3:0] c, input logic [31:0] d,
                          input logic [3:0] be, input int wi, input int wb);
        logic [5:0] h = exp_hit(a, c);
        frame_n = 1'b0; ad = a; cbe_n = c; irdy_n = 1'b1; be_rdy_n = 1'b1;
        step();
        chk(be_addr == a, "R1 addr", be_addr, a);
        chk(be_rnw == ~c[0], "R1 rnw", 32'(be_rnw), 32'(~c[0]));
        frame_n = 1'b1; ad = d; cbe_n = be; irdy_n = (wi == 0) ? 1'b0 : 1'b1;
        step();
        chk(be_hit == h, "R2 hit", 32'(be_hit), 32'(h));
        chk(devsel_n == 1'b1, "R3 devsel early", 32'(devsel_n), 1);
        if (h == 6'd0) begin
            for (int k = 0; k < 3; k++) begin
                irdy_n = 1'b0;
                step();
                chk(devsel_n && trdy_n && be_xfer_n, "R4 ignored",
                    {devsel_n, trdy_n, be_xfer_n}, 3'b111);
            end
            irdy_n = 1'b1;
            step();
            return;
        end
        step();
        chk(devsel_n == 1'b0, "R3 devsel", 32'(devsel_n), 0);
        for (int k = 0; k < 200; k++) begin
            irdy_n   = (k < wi) ? 1'b1 : 1'b0;
            be_rdy_n = (k < wb) ? 1'b1 : 1'b0;
            step();
            if (!irdy_n && !be_rdy_n) begin
                chk(!trdy_n && !be_xfer_n, "R5 strobe", {trdy_n, be_xfer_n}, 0);
                chk(be_data == d, "R6 data", be_data, d);
                chk(be_byten == ~be, "R6 byten", 32'(be_byten), 32'(~be));
                break;
            end
            chk(trdy_n && be_xfer_n && !devsel_n, "R7 wait", {devsel_n, trdy_n, be_xfer_n}, 3'b011);
        end
        be_rdy_n = 1'b1;
        step();
        chk(devsel_n && trdy_n && be_xfer_n && be_hit == 0, "R8 release",
            {be_hit, devsel_n, trdy_n, be_xfer_n}, 9'b000000111);
        irdy_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        chk(devsel_n && trdy_n && be_xfer_n && be_hit == 0 && be_byten == 0, "R10 reset",
            {be_byten, be_hit, devsel_n, trdy_n, be_xfer_n}, 13'h7);
        rst_n = 1'b1;
        step();
        // directed corners
        run_tx(32'h0000_1004, 4'b0111, 32'hDEAD_BEEF, 4'b0000, 0, 0);   // fastest
        run_tx(32'h0000_6FFC, 4'b0111, 32'h1234_5678, 4'b1010, 0, 20);  // R9 b2b, last region, long wait
        run_tx(32'h0000_7000, 4'b0111, 32'h0, 4'b0000, 0, 0);           // R4 miss above top
        run_tx(32'h0000_0FFC, 4'b0111, 32'h0, 4'b0000, 0, 0);           // R4 miss below
        run_tx(32'h0000_3000, 4'b0110, 32'h0, 4'b0000, 0, 0);           // R4 read cmd ignored
        run_tx(32'h0000_3010, 4'b0111, 32'hCAFE_0001, 4'b0111, 5, 2);   // R7 initiator waits
        step(); step();
        for (int t = 0; t < 80; t++) begin
            int r = int'($urandom_range(0, 6));
            logic [31:0] a = {20'(r + 1), 12'($urandom)};
            logic [3:0] c = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'b0111;
            run_tx(a, c, $urandom, 4'($urandom), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 6)));
            if ($urandom_range(0, 1) == 1) step();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule